// File: doc/BRIEF.md
# Dual Decimal Counter Adder with Seven-Segment Display

The block keeps two independent counters, A and B, each covering 0 to 99. A divider produces a slow step pulse from the system clock; the default ratio gives roughly 2 Hz from a 50 MHz clock. On each step, every counter whose push button is held moves one place. One shared direction switch sets whether both counters count up or down. Each counter wraps at the ends of its range.

The block adds the two counts continuously. Six seven-segment outputs show the tens and units of A, the tens and units of B, and the low two decimal digits of the sum. A sum of 100 or more (at most 198) lights all ten LEDs of a bar, which stands for the hundreds digit. Buttons and the switch are asynchronous board inputs, so they pass through a two-flop synchronizer before use.

Each counter is a small three-state machine:
- ST_HOLD is the state while the button is released.
- ST_UP is the state while the button is held and the switch is high.
- ST_DOWN is the state while the button is held and the switch is low.

The state is recomputed from the synchronized inputs on every clock. Transitions between any two states happen directly whenever those inputs change. The count moves only on a step pulse, by the rule of the current state.

Top module: `dual_count_adder`

## Requirements
- R1: In ST_UP a counter increases by one per step, stays within 0..99, and wraps from 99 to 0.
- R2: In ST_DOWN a counter decreases by one per step and wraps from 0 to 99.
- R3: After reset is released, counters change only at clock edges TICK_DIV, 2*TICK_DIV, 3*TICK_DIV, ... counted from the first edge with reset low, and never between them.
- R4: `key_a_n` and `key_b_n` are active-low enables (0 = held). A counter whose button is released holds its value, and each counter responds only to its own button.
- R5: `dir_up` = 1 makes both counters count up and `dir_up` = 0 makes both count down. All three inputs pass through two synchronizer flops and the state register, so a change applied at least three edges before a step governs that step.
- R6: `hex_a_hi`/`hex_a_lo` show the tens/units digit of A and `hex_b_hi`/`hex_b_lo` show the tens/units digit of B.
- R7: `hex_s_hi`/`hex_s_lo` show the tens/units digit of (A+B) mod 100.
- R8: `bar` is 10'h3FF when A+B >= 100 and 10'h000 otherwise.
- R9: Segment buses are active-low with bit 0 = segment a through bit 6 = segment g. The digits 0..9 are coded 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00, 7'h10; any other value is blank (7'h7F).
- R10: A synchronous reset (`rst` = 1) clears both counters, the divider and the machines. All digits then show 0, the bar is dark, and the step timing of R3 restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_a_n | input | 1 | Counter A enable button, active low |
| key_b_n | input | 1 | Counter B enable button, active low |
| dir_up | input | 1 | Shared direction: 1 up, 0 down |
| hex_a_hi | output | 7 | Counter A tens digit segments |
| hex_a_lo | output | 7 | Counter A units digit segments |
| hex_b_hi | output | 7 | Counter B tens digit segments |
| hex_b_lo | output | 7 | Counter B units digit segments |
| hex_s_hi | output | 7 | Sum tens digit segments |
| hex_s_lo | output | 7 | Sum units digit segments |
| bar | output | 10 | Hundreds indicator, all on or all off |

## Verification
A button or switch change counts toward a step only when it lands three edges before that step: two synchronizer flops plus the state register. The counters then move on the step edge itself, and the segment and bar outputs follow combinationally in the same cycle. The bench therefore changes its inputs only just after a step edge, and checks every output twice per step period. The first check comes one edge before the step, when nothing may yet have moved. The second comes just after the step edge, against a model updated once.

// File: rtl/dca_pkg.sv
package dca_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

    // Active-low segments, bit 0 = a ... bit 6 = g
    function automatic logic [6:0] seg_encode(input logic [3:0] digit);
        logic [6:0] lit;
        case (digit)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/dca_tick_gen.sv
module dca_tick_gen #(
    parameter int TICK_DIV = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst)                  div_cnt <= '0;
        else if (div_cnt == LAST) div_cnt <= '0;
        else                      div_cnt <= div_cnt + 1'b1;
    end

    assign tick = (div_cnt == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/dca_sync.sv
module dca_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/dca_counter.sv
module dca_counter
    import dca_pkg::*;
#(
    parameter int MOD   = 100,
    parameter int CNT_W = $clog2(MOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             up,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MOD - 1);

    cnt_state_e state, state_nx;

    always_comb begin
        if (!en)     state_nx = ST_HOLD;
        else if (up) state_nx = ST_UP;
        else         state_nx = ST_DOWN;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nx;
    end

    // Count register, stepped by the current state
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            unique case (state)
                ST_UP:   cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
                ST_DOWN: cnt <= (cnt == '0) ? TOP : cnt - 1'b1;
                ST_HOLD: cnt <= cnt;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP); // R1
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_UP && cnt == TOP) |=> (cnt == '0)); // R1
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_DOWN && cnt == '0) |=> (cnt == TOP)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick || state == ST_HOLD) |=> $stable(cnt)); // R4

endmodule

// File: rtl/dual_count_adder.sv
module dual_count_adder
    import dca_pkg::*;
#(
    parameter int TICK_DIV = 25_000_000,
    parameter int MOD      = 100,
    parameter int LED_W    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_a_n,
    input  logic             key_b_n,
    input  logic             dir_up,
    output logic [6:0]       hex_a_hi,
    output logic [6:0]       hex_a_lo,
    output logic [6:0]       hex_b_hi,
    output logic [6:0]       hex_b_lo,
    output logic [6:0]       hex_s_hi,
    output logic [6:0]       hex_s_lo,
    output logic [LED_W-1:0] bar
);
    localparam int CNT_W  = $clog2(MOD);
    localparam int SUM_W  = CNT_W + 1;
    localparam int NDIG   = 6;
    localparam int DEC    = 10;

    logic             tick;
    logic [2:0]       sync_q;
    logic [CNT_W-1:0] cnt_a, cnt_b;
    logic [SUM_W-1:0] sum, sum_lo;
    logic             carry;
    logic [3:0]       digit [NDIG];
    logic [6:0]       seg   [NDIG];

    dca_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    dca_sync #(.STAGES(2), .W(3), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst(rst),
        .din({dir_up, key_b_n, key_a_n}),
        .dout(sync_q)
    );

    dca_counter #(.MOD(MOD), .CNT_W(CNT_W)) u_cnt_a (
        .clk(clk), .rst(rst), .tick(tick),
        .en(!sync_q[0]), .up(sync_q[2]), .cnt(cnt_a)
    );

    dca_counter #(.MOD(MOD), .CNT_W(CNT_W)) u_cnt_b (
        .clk(clk), .rst(rst), .tick(tick),
        .en(!sync_q[1]), .up(sync_q[2]), .cnt(cnt_b)
    );

    always_comb begin
        sum      = SUM_W'(cnt_a) + SUM_W'(cnt_b);
        carry    = (sum >= SUM_W'(MOD));
        sum_lo   = carry ? sum - SUM_W'(MOD) : sum;
        digit[0] = 4'(cnt_a / CNT_W'(DEC));
        digit[1] = 4'(cnt_a % CNT_W'(DEC));
        digit[2] = 4'(cnt_b / CNT_W'(DEC));
        digit[3] = 4'(cnt_b % CNT_W'(DEC));
        digit[4] = 4'(sum_lo / SUM_W'(DEC));
        digit[5] = 4'(sum_lo % SUM_W'(DEC));
    end

    for (genvar g = 0; g < NDIG; g++) begin : g_seg
        assign seg[g] = seg_encode(digit[g]);
    end

    assign hex_a_hi = seg[0];
    assign hex_a_lo = seg[1];
    assign hex_b_hi = seg[2];
    assign hex_b_lo = seg[3];
    assign hex_s_hi = seg[4];
    assign hex_s_lo = seg[5];
    assign bar      = {LED_W{carry}};

    AST_BAR_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (bar == '0) || (&bar)); // R8

endmodule

// File: tb/dual_count_adder_test.sv
`timescale 1ns/1ps
module dual_count_adder_test;
    localparam int TDIV = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_a_n = 1'b1, key_b_n = 1'b1, dir_up = 1'b1;
    logic [6:0] hex_a_hi, hex_a_lo, hex_b_hi, hex_b_lo, hex_s_hi, hex_s_lo;
    logic [9:0] bar;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int ma = 0, mb = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_count_adder #(.TICK_DIV(TDIV)) uut (
        .clk(clk), .rst(rst), .key_a_n(key_a_n), .key_b_n(key_b_n),
        .dir_up(dir_up), .hex_a_hi(hex_a_hi), .hex_a_lo(hex_a_lo),
        .hex_b_hi(hex_b_hi), .hex_b_lo(hex_b_lo), .hex_s_hi(hex_s_hi),
        .hex_s_lo(hex_s_lo), .bar(bar)
    );

    function automatic logic [6:0] ref_seg(int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; 9: return 7'h10; default: return 7'h7F;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_display(string tag);
        int s = ma + mb;
        check({tag, " R6 R9 a_hi"}, hex_a_hi, ref_seg(ma / 10));
        check({tag, " R6 R9 a_lo"}, hex_a_lo, ref_seg(ma % 10));
        check({tag, " R6 R9 b_hi"}, hex_b_hi, ref_seg(mb / 10));
        check({tag, " R6 R9 b_lo"}, hex_b_lo, ref_seg(mb % 10));
        check({tag, " R7 s_hi"}, hex_s_hi, ref_seg((s % 100) / 10));
        check({tag, " R7 s_lo"}, hex_s_lo, ref_seg(s % 10));
        check({tag, " R8 bar"}, bar, (s >= 100) ? 10'h3FF : 10'h000);
    endtask

    // Entered and left at the falling edge just after a step edge.
    task automatic run_ticks(int n, bit pa, bit pb, bit up, string tag);
        key_a_n = !pa; key_b_n = !pb; dir_up = up;
        for (int i = 0; i < n; i++) begin
            repeat (TDIV - 1) @(negedge clk);
            check_display({tag, " R3 mid"});
            @(negedge clk);
            if (pa) ma = up ? (ma + 1) % 100 : (ma + 99) % 100;
            if (pb) mb = up ? (mb + 1) % 100 : (mb + 99) % 100;
            check_display(tag);
        end
    endtask

    task automatic do_reset(string tag);
        key_a_n = 1'b1; key_b_n = 1'b1; dir_up = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ma = 0; mb = 0;
        check_display(tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset("R10 reset");
        run_ticks(5, 1, 0, 1, "R4 R5 A only up");
        run_ticks(3, 0, 1, 1, "R4 B only up");
        run_ticks(120, 1, 1, 1, "R1 R8 both up");
        run_ticks(130, 1, 1, 0, "R2 R5 both down");
        run_ticks(4, 0, 0, 0, "R4 idle");
        run_ticks(7, 1, 0, 1, "R1 A up again");
        do_reset("R10 mid-run reset");
        run_ticks(3, 1, 1, 0, "R10 R3 restart down");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule